// File: doc/BRIEF.md
# ISA Cycle Sequencer with Wait States

This block runs 8-bit ISA bus cycles for a host processor that completes every access in a single clock and cannot be stalled. A host access to the ISA window records the direction, the address space (memory or I/O, taken from address bit 8) and the write byte. The ISA cycle itself starts only when the window select coincides with the CPU's opcode-fetch indicator. This keeps an indexed instruction's early, unindexed address phase from launching a bogus cycle.

Once started, the sequencer pulls exactly one of the four active-low strobes low. It holds that strobe for one clock, plus one more clock for every clock in which the card reports not ready. It then spends one recovery clock with all strobes high and a clear pulse low. Write cycles enable the held byte onto the ISA data bus. Read cycles store the bus value into a holding register, and the host collects it later with a second access.

A small interrupt collector merges six ISA interrupt lines into the host's single active-low interrupt. It also produces the active-high card reset.

Top module: `isa_cycle_engine`

## Requirements
- R1: While `rst_n_host` is low, and on the clock after it is released, all four strobes are high, `isa_d_oe` is 0, `clr_n` is 1, `host_irq_n` is 1 and `hold_data` is 0.
- R2: A cycle starts only on a clock edge at which `win_sel` and `host_sync` are both 1. With `host_sync` at 0, a window select leaves every strobe high.
- R3: In the clock after a qualifying edge, exactly one strobe is low. A read (`host_rnw`=1) with `host_a8`=1 lowers `isa_memr_n`, and with `host_a8`=0 it lowers `isa_ior_n`. A write (`host_rnw`=0) with `host_a8`=1 lowers `isa_memw_n`, and with `host_a8`=0 it lowers `isa_iow_n`.
- R4: The strobe stays low for 1 + N clocks, where N is the number of consecutive edges during the strobe at which `isa_chrdy` is sampled 0.
- R5: The clock after the strobe is released is a recovery clock. In it all strobes are high and `clr_n` is 0, for exactly one clock. The block is then idle and can accept a new cycle.
- R6: During a write strobe, `isa_d_oe` is 1 and `isa_d_out` carries the recorded write byte. `isa_d_oe` is 0 at all other times.
- R7: `hold_data` takes the `isa_d_in` value sampled at the edge that ends a read strobe. Write cycles leave `hold_data` unchanged.
- R8: While idle, every edge with `win_sel`=1 records the request, so the last window access before the cycle starts wins. Window accesses during a running cycle do not change its strobe or data.
- R9: A 0-to-1 transition of the OR of the six `isa_irq` lines sets the interrupt flag at that edge, and `host_irq_n` is then 0. A line that simply stays high does not set the flag again after it has been cleared.
- R10: The flag clears at an edge where a read strobe (`isa_memr_n` or `isa_ior_n`) is low. A rising interrupt at the same edge takes precedence and keeps the flag set.
- R11: `isa_reset` is the inverse of `rst_n_host` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_host | input | 1 | Host reset, active low, sampled synchronously |
| win_sel | input | 1 | Host access falls in the ISA window |
| host_sync | input | 1 | Host opcode-fetch (instruction boundary) indicator |
| host_rnw | input | 1 | Host direction, 1 = read |
| host_a8 | input | 1 | Host address bit 8, 1 = memory space, 0 = I/O space |
| host_wdata | input | 8 | Host write byte |
| isa_chrdy | input | 1 | Card ready, 0 = insert wait state |
| isa_d_in | input | 8 | ISA data bus input |
| isa_irq | input | 6 | ISA interrupt lines, active high |
| isa_memr_n | output | 1 | Memory read strobe |
| isa_memw_n | output | 1 | Memory write strobe |
| isa_ior_n | output | 1 | I/O read strobe |
| isa_iow_n | output | 1 | I/O write strobe |
| isa_d_out | output | 8 | ISA data bus output |
| isa_d_oe | output | 1 | ISA data bus output enable |
| hold_data | output | 8 | Read data held for the host |
| clr_n | output | 1 | Recovery clear pulse, active low |
| host_irq_n | output | 1 | Host interrupt, active low |
| isa_reset | output | 1 | Card reset, active high |

## Verification
The assertions watch, on every clock, the rules that link neighbouring cycles. These are: at most one strobe low, a strobe frozen while the card is not ready, a single-clock clear after each strobe, no strobe without a qualified start, write enable only under a write strobe, and the interrupt output falling after a rising request. Other behaviour needs the bench's scenarios, because it depends on values carried across several accesses. That covers which strobe matches a given request, the exact stretched length, the captured read byte, the last-wins request recording, and interrupt clearing by read cycles.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_STROBE  = 2'b01,
        ST_RECOVER = 2'b10,
        ST_SPARE   = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic memr_n;
        logic memw_n;
        logic ior_n;
        logic iow_n;
    } strobe_t;

    typedef struct packed {
        logic rnw;
        logic mem_space;
    } req_t;

    localparam strobe_t STROBE_OFF = 4'b1111;

    // Select the single active-low strobe for a request.
    function automatic strobe_t strobe_decode(input req_t r);
        strobe_t s;
        s        = STROBE_OFF;
        s.memr_n = !(r.rnw && r.mem_space);
        s.ior_n  = !(r.rnw && !r.mem_space);
        s.memw_n = !(!r.rnw && r.mem_space);
        s.iow_n  = !(!r.rnw && !r.mem_space);
        return s;
    endfunction

endpackage

// File: rtl/isa_req_latch.sv
module isa_req_latch
    import isa_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  req_t              req_in,
    input  logic [DATA_W-1:0] data_in,
    output req_t              req_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            data_q <= '0;
        end else if (capture) begin
            req_q  <= req_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/isa_read_hold.sv
module isa_read_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= bus_in;
    end
endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
    import isa_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ready,
    output logic active,
    output logic recover,
    output logic done
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_STROBE;
            ST_STROBE:  if (ready) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign active  = (state_q == ST_STROBE);
    assign recover = (state_q == ST_RECOVER);
    assign done    = active && ready;

    // Idle indicator is used by the request latch via top (start/capture).
endmodule

// File: rtl/isa_irq_collector.sv
module isa_irq_collector #(
    parameter int IRQ_N = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] irq_lines,
    input  logic             read_clear,
    output logic             irq_n
);
    logic any_q;
    logic any_d;
    logic flag_q;

    assign any_d = |irq_lines;

    // Edge reference follows the merged level even in reset, so a line
    // already high when reset ends does not count as a new edge.
    always_ff @(posedge clk) any_q <= any_d;

    always_ff @(posedge clk) begin
        if (rst)                    flag_q <= 1'b0;
        else if (any_d && !any_q)   flag_q <= 1'b1;
        else if (read_clear)        flag_q <= 1'b0;
    end

    assign irq_n = !flag_q;
endmodule

// File: rtl/isa_cycle_engine.sv
module isa_cycle_engine
    import isa_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IRQ_N  = 6
) (
    input  logic              clk,
    input  logic              rst_n_host,
    input  logic              win_sel,
    input  logic              host_sync,
    input  logic              host_rnw,
    input  logic              host_a8,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              isa_chrdy,
    input  logic [DATA_W-1:0] isa_d_in,
    input  logic [IRQ_N-1:0]  isa_irq,
    output logic              isa_memr_n,
    output logic              isa_memw_n,
    output logic              isa_ior_n,
    output logic              isa_iow_n,
    output logic [DATA_W-1:0] isa_d_out,
    output logic              isa_d_oe,
    output logic [DATA_W-1:0] hold_data,
    output logic              clr_n,
    output logic              host_irq_n,
    output logic              isa_reset
);
    logic    rst;
    logic    active, recover, done, busy;
    req_t    req_in, req_q;
    strobe_t strobes;

    assign rst       = !rst_n_host;
    assign isa_reset = !rst_n_host;

    assign req_in.rnw       = host_rnw;
    assign req_in.mem_space = host_a8;
    assign busy             = active || recover;

    isa_cycle_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (win_sel && host_sync),
        .ready   (isa_chrdy),
        .active  (active),
        .recover (recover),
        .done    (done)
    );

    isa_req_latch #(.DATA_W(DATA_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .capture (win_sel && !busy),
        .req_in  (req_in),
        .data_in (host_wdata),
        .req_q   (req_q),
        .data_q  (isa_d_out)
    );

    isa_read_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (done && req_q.rnw),
        .bus_in (isa_d_in),
        .held   (hold_data)
    );

    isa_irq_collector #(.IRQ_N(IRQ_N)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .irq_lines  (isa_irq),
        .read_clear (!isa_memr_n || !isa_ior_n),
        .irq_n      (host_irq_n)
    );

    assign strobes    = active ? strobe_decode(req_q) : STROBE_OFF;
    assign isa_memr_n = strobes.memr_n;
    assign isa_memw_n = strobes.memw_n;
    assign isa_ior_n  = strobes.ior_n;
    assign isa_iow_n  = strobes.iow_n;
    assign isa_d_oe   = active && !req_q.rnw;
    assign clr_n      = !recover;
endmodule

// File: rtl/isa_cycle_engine_chk.sv
module isa_cycle_engine_chk #(
    parameter int IRQ_N = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             win_sel,
    input logic             host_sync,
    input logic             isa_chrdy,
    input logic [IRQ_N-1:0] isa_irq,
    input logic             isa_memr_n,
    input logic             isa_memw_n,
    input logic             isa_ior_n,
    input logic             isa_iow_n,
    input logic             isa_d_oe,
    input logic             clr_n,
    input logic             host_irq_n
);
    logic [3:0] stb;
    logic       all_high;
    assign stb      = {isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n};
    assign all_high = &stb;

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~stb) <= 1);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!all_high && !isa_chrdy) |=> $stable(stb));

    // R5
    clear_after_chk: assert property (@(posedge clk) disable iff (rst)
        (!all_high && isa_chrdy) |=> (all_high && !clr_n));

    // R5
    clear_single_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> clr_n);

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (all_high && clr_n && !(win_sel && host_sync)) |=> all_high);

    // R6
    oe_write_chk: assert property (@(posedge clk) disable iff (rst)
        isa_d_oe |-> (!isa_memw_n || !isa_iow_n));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|isa_irq) |=> !host_irq_n);
endmodule

bind isa_cycle_engine isa_cycle_engine_chk #(.IRQ_N(IRQ_N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .win_sel    (win_sel),
    .host_sync  (host_sync),
    .isa_chrdy  (isa_chrdy),
    .isa_irq    (isa_irq),
    .isa_memr_n (isa_memr_n),
    .isa_memw_n (isa_memw_n),
    .isa_ior_n  (isa_ior_n),
    .isa_iow_n  (isa_iow_n),
    .isa_d_oe   (isa_d_oe),
    .clr_n      (clr_n),
    .host_irq_n (host_irq_n)
);

// File: tb/test_isa_cycle_engine.sv
module test_isa_cycle_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n_host, win_sel, host_sync, host_rnw, host_a8, isa_chrdy;
    logic [7:0] host_wdata, isa_d_in, isa_d_out, hold_data;
    logic [5:0] isa_irq;
    logic       isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n, isa_d_oe;
    logic       clr_n, host_irq_n, isa_reset;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_hold = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_cycle_engine i_isa_cycle_engine (
        .clk(clk), .rst_n_host(rst_n_host), .win_sel(win_sel), .host_sync(host_sync),
        .host_rnw(host_rnw), .host_a8(host_a8), .host_wdata(host_wdata),
        .isa_chrdy(isa_chrdy), .isa_d_in(isa_d_in), .isa_irq(isa_irq),
        .isa_memr_n(isa_memr_n), .isa_memw_n(isa_memw_n), .isa_ior_n(isa_ior_n),
        .isa_iow_n(isa_iow_n), .isa_d_out(isa_d_out), .isa_d_oe(isa_d_oe),
        .hold_data(hold_data), .clr_n(clr_n), .host_irq_n(host_irq_n),
        .isa_reset(isa_reset)
    );

    // Expected strobes {memr_n, memw_n, ior_n, iow_n}
    function automatic logic [3:0] exp_strobe(input logic rnw, input logic a8);
        return {!(rnw && a8), !(!rnw && a8), !(rnw && !a8), !(!rnw && !a8)};
    endfunction

    function automatic logic [3:0] cur_strobe();
        return {isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Full cycle: qualify, strobe for waits+1 clocks, recovery, idle.
    task automatic run_cycle(input logic rnw, input logic a8, input logic [7:0] wd,
                             input int waits, input logic [7:0] rd, input logic noise);
        win_sel = 1; host_sync = 1; host_rnw = rnw; host_a8 = a8; host_wdata = wd;
        tick();
        win_sel = 0; host_sync = 0;
        for (int i = 0; i <= waits; i++) begin
            isa_chrdy = (i == waits);
            isa_d_in  = rd;
            if (noise) begin
                // R8: window accesses during a running cycle are ignored
                win_sel = 1; host_rnw = !rnw; host_a8 = !a8; host_wdata = ~wd;
            end
            check(cur_strobe() == exp_strobe(rnw, a8), "R3/R4 strobe",
                  cur_strobe(), exp_strobe(rnw, a8));
            check(isa_d_oe == !rnw, "R6 oe", isa_d_oe, !rnw);
            if (!rnw) check(isa_d_out == wd, "R6/R8 data", isa_d_out, wd);
            tick();
        end
        win_sel = 0; isa_chrdy = 1; isa_d_in = ~rd;
        if (rnw) exp_hold = rd;
        check(cur_strobe() == 4'hF, "R4/R5 released", cur_strobe(), 4'hF);
        check(clr_n == 0, "R5 clear low", clr_n, 0);
        check(isa_d_oe == 0, "R6 oe off", isa_d_oe, 0);
        check(hold_data == exp_hold, "R7 hold", hold_data, exp_hold);
        tick();
        check(clr_n == 1, "R5 clear single", clr_n, 1);
        check(cur_strobe() == 4'hF, "R5 idle", cur_strobe(), 4'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'h5eed_1a5a));
        rst_n_host = 0; win_sel = 0; host_sync = 0; host_rnw = 1; host_a8 = 0;
        host_wdata = 0; isa_chrdy = 1; isa_d_in = 0; isa_irq = 0;
        tick();
        check(isa_reset == 1, "R11 reset high", isa_reset, 1);
        tick();
        check(cur_strobe() == 4'hF, "R1 strobes", cur_strobe(), 4'hF);
        rst_n_host = 1;
        #1;
        check(isa_reset == 0, "R11 reset low", isa_reset, 0);
        tick();
        check(cur_strobe() == 4'hF && clr_n && !isa_d_oe, "R1 idle outputs",
              {cur_strobe(), clr_n, isa_d_oe}, 6'b111110);
        check(host_irq_n == 1, "R1 irq", host_irq_n, 1);
        check(hold_data == 0, "R1 hold", hold_data, 0);

        // R2: select without SYNC never strobes
        win_sel = 1; host_sync = 0; host_rnw = 0; host_a8 = 1; host_wdata = 8'h11;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(cur_strobe() == 4'hF, "R2 no sync", cur_strobe(), 4'hF);
        end
        win_sel = 0; host_sync = 1;
        tick();
        check(cur_strobe() == 4'hF, "R2 sync without select", cur_strobe(), 4'hF);
        host_sync = 0;

        // R3: all four strobe kinds, directed
        run_cycle(1, 1, 8'h00, 0, 8'hA5, 0);
        run_cycle(1, 0, 8'h00, 0, 8'h3C, 0);
        run_cycle(0, 1, 8'h5A, 0, 8'hFF, 0);
        run_cycle(0, 0, 8'hC3, 0, 8'h00, 0);
        // R4: long wait states; R8: noise during cycle
        run_cycle(1, 1, 8'h00, 5, 8'h77, 1);
        run_cycle(0, 0, 8'h99, 3, 8'h12, 1);

        // R8: last window access before qualification wins
        win_sel = 1; host_sync = 0; host_rnw = 0; host_a8 = 1; host_wdata = 8'hEE;
        tick();
        run_cycle(1, 0, 8'h00, 1, 8'h42, 0);

        // R9: rising interrupt sets flag
        isa_irq = 6'b000100;
        tick();
        check(host_irq_n == 0, "R9 set", host_irq_n, 0);
        // write cycle does not clear
        run_cycle(0, 1, 8'h01, 0, 8'h00, 0);
        check(host_irq_n == 0, "R10 write keeps", host_irq_n, 0);
        // read cycle clears
        run_cycle(1, 1, 8'h00, 0, 8'h81, 0);
        check(host_irq_n == 1, "R10 read clears", host_irq_n, 1);
        // held level does not re-set
        tick();
        check(host_irq_n == 1, "R9 level no reset", host_irq_n, 1);
        // second line rising while first high: OR has no new edge
        isa_irq = 6'b100100;
        tick();
        check(host_irq_n == 1, "R9 OR no edge", host_irq_n, 1);
        isa_irq = 0;
        tick();
        // R10: rising edge coinciding with read strobe keeps flag set
        win_sel = 1; host_sync = 1; host_rnw = 1; host_a8 = 0;
        tick();
        win_sel = 0; host_sync = 0; isa_chrdy = 1; isa_irq = 6'b000001;
        tick();
        check(host_irq_n == 0, "R10 set wins", host_irq_n, 0);
        isa_irq = 0;
        tick();
        exp_hold = isa_d_in;
        check(hold_data == exp_hold, "R7 hold directed", hold_data, exp_hold);
        tick();

        // Random mix
        for (int k = 0; k < 60; k++) begin
            logic rnw, a8;
            logic [7:0] wd, rd;
            int w;
            rnw = 1'($urandom);
            a8  = 1'($urandom);
            wd  = 8'($urandom);
            rd  = 8'($urandom);
            w   = int'($urandom % 4);
            run_cycle(rnw, a8, wd, w, rd, 1'($urandom));
        end
        report();
    end
endmodule